// File: doc/BRIEF.md
# Auxiliary DAC Control Register Bank

This block keeps the digital side of three auxiliary converter channels: one for receiver gain control, one for the tuning voltage of an external reference oscillator, and one for transmit power ramping. Software writes each channel's code and a shared power register over a simple address/data/strobe bus. An external standby pin, usually tied to the same signal that switches the oscillator, gates the whole section. The converters themselves are not part of this block. Each channel shows up here only as a code bus, an output-enable that stands for a driven analog output (low means floating), and a clock enable.

A channel is active only while the synchronized standby pin is high and its own power bit is set. The code that reaches a channel's output is captured in an output stage. That stage follows the code register while the channel is active and freezes while it is inactive. When a channel is re-enabled, it therefore presents whatever code it already holds, and no fresh write is needed.

Top module: `aux_dac_bank`

## Requirements
- R1: The gain, frequency and ramp channels are 8, 12 and 10 bits wide. A code write keeps only the low bits of the data word that fit the channel.
- R2: `dac_oe_o[n]` and `dac_clk_en_o[n]` are high only when the synchronized standby level is high and power bit n is set. Channel index 0 is gain, 1 is frequency and 2 is ramp.
- R3: After reset, the power register reads 3'b010. The gain and ramp code registers and outputs are 0. The frequency code register and output are 0x800 (mid-scale). All enables stay low until standby is seen high.
- R4: A code write to an active channel appears on its code output at the same clock edge that loads the register.
- R5: A code write to an inactive channel updates the register, which can be read back, and leaves the channel's code output unchanged.
- R6: An inactive channel whose power bit is set presents its held code on the third clock edge after standby is driven high. A channel enabled by a power-register write presents its held code on the second edge after the write.
- R7: Register addresses are 0 for power (bits [2:0], bit n controls channel n), 1 for gain code, 2 for frequency code and 3 for ramp code. Read data is combinational from `rd_addr_i` and zero-extended.
- R8: The standby pin passes through a two-flop synchronizer. A change on it reaches the enables at the second rising clock edge.
- R9: Asserting `rst_n` low clears the state at once, without waiting for a clock edge. Its release is synchronized over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | External standby pin, high = section active (asynchronous) |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W | Read data, zero-extended |
| gain_code_o | output | GAIN_W | Gain channel code |
| freq_code_o | output | FREQ_W | Frequency channel code |
| ramp_code_o | output | RAMP_W | Ramp channel code |
| dac_oe_o | output | 3 | Per-channel output drive enable |
| dac_clk_en_o | output | 3 | Per-channel clock enable |

## Verification
A corrupted power bit shows on the matching enable pair and in the power read-back within one edge. A wrong code register shows on the read port at once. It reaches the code bus only once the channel is active, so the bench compares held and presented codes separately at every cycle. A wrong synchronizer depth moves the enable edges away from the second edge after a standby change, and the directed standby steps check the exact cycle of that move. A cycle-accurate reference model in the bench tracks random writes and standby toggles, so a stale or prematurely updated output stage is caught in the first cycle it diverges.

// File: rtl/aux_dac_pkg.sv
package aux_dac_pkg;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_PWR  = 2'd0,
    A_GAIN = 2'd1,
    A_FREQ = 2'd2,
    A_RAMP = 2'd3
  } aux_addr_e;
endpackage

// File: rtl/aux_sync2.sv
module aux_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {2{RST_VAL}};
    else        stg_q <= {stg_q[0], d_i};
  end

  assign q_o = stg_q[1];
endmodule

// File: rtl/aux_dac_chan.sv
module aux_dac_chan #(
  parameter int unsigned W        = 8,
  parameter int unsigned DATA_W   = 16,
  parameter logic [W-1:0] RST_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pwr_i,
  input  logic              standby_i,
  output logic [W-1:0]      held_o,
  output logic [W-1:0]      code_o,
  output logic              oe_o,
  output logic              clk_en_o
);
  logic         en;
  logic [W-1:0] held_d, held_q;
  logic [W-1:0] out_d, out_q;

  assign en = pwr_i & standby_i;

  always_comb begin
    held_d = held_q;
    if (sel_wr_i) held_d = wr_data_i[W-1:0];
    out_d = out_q;
    if (en) out_d = held_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= RST_CODE;
      out_q  <= RST_CODE;
    end else begin
      held_q <= held_d;
      out_q  <= out_d;
    end
  end

  assign held_o   = held_q;
  assign code_o   = out_q;
  assign oe_o     = en;
  assign clk_en_o = en;

  // R5: an inactive channel keeps its presented code
  p_hold_inactive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |=> $stable(code_o));

  // R4: a write to an active channel is presented at the loading edge
  p_write_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && sel_wr_i) |=> (code_o == $past(wr_data_i[W-1:0])));

  // R6: an active channel without a write presents its held code
  p_show_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && !sel_wr_i) |=> (code_o == $past(held_o)));

  // R2: enables need both power and standby
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o || clk_en_o) |-> (pwr_i && standby_i));
endmodule

// File: rtl/aux_dac_bank.sv
module aux_dac_bank
  import aux_dac_pkg::*;
#(
  parameter int unsigned GAIN_W  = 8,
  parameter int unsigned FREQ_W  = 12,
  parameter int unsigned RAMP_W  = 10,
  parameter int unsigned DATA_W  = 16,
  parameter logic [2:0]  PWR_RST = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [GAIN_W-1:0] gain_code_o,
  output logic [FREQ_W-1:0] freq_code_o,
  output logic [RAMP_W-1:0] ramp_code_o,
  output logic [2:0]        dac_oe_o,
  output logic [2:0]        dac_clk_en_o
);
  localparam int unsigned GF_W = (GAIN_W > FREQ_W) ? GAIN_W : FREQ_W;
  localparam int unsigned CW   = (GF_W > RAMP_W) ? GF_W : RAMP_W;

  logic                rst_sync_n;
  logic                sb_sync;
  logic [NUM_CH-1:0]   pwr_d, pwr_q;
  logic [CW-1:0]       held_arr [NUM_CH];
  logic [CW-1:0]       out_arr  [NUM_CH];

  aux_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_sync_n)
  );

  aux_sync2 #(.RST_VAL(1'b0)) u_sb_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(standby_i), .q_o(sb_sync)
  );

  always_comb begin
    pwr_d = pwr_q;
    if (wr_en_i && (wr_addr_i == A_PWR)) pwr_d = wr_data_i[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pwr_q <= PWR_RST;
    else             pwr_q <= pwr_d;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int unsigned W = (ch == 0) ? GAIN_W : (ch == 1) ? FREQ_W : RAMP_W;
    localparam logic [W-1:0] RC = (ch == 1) ? {1'b1, {(W-1){1'b0}}} : '0;
    logic [W-1:0] held, code;
    logic         sel_wr;

    assign sel_wr = wr_en_i && (wr_addr_i == 2'(ch + 1));

    aux_dac_chan #(.W(W), .DATA_W(DATA_W), .RST_CODE(RC)) u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .sel_wr_i  (sel_wr),
      .wr_data_i (wr_data_i),
      .pwr_i     (pwr_q[ch]),
      .standby_i (sb_sync),
      .held_o    (held),
      .code_o    (code),
      .oe_o      (dac_oe_o[ch]),
      .clk_en_o  (dac_clk_en_o[ch])
    );

    assign held_arr[ch] = CW'(held);
    assign out_arr[ch]  = CW'(code);
  end

  assign gain_code_o = out_arr[0][GAIN_W-1:0];
  assign freq_code_o = out_arr[1][FREQ_W-1:0];
  assign ramp_code_o = out_arr[2][RAMP_W-1:0];

  always_comb begin
    unique case (rd_addr_i)
      A_PWR:   rd_data_o = DATA_W'(pwr_q);
      A_GAIN:  rd_data_o = DATA_W'(held_arr[0]);
      A_FREQ:  rd_data_o = DATA_W'(held_arr[1]);
      default: rd_data_o = DATA_W'(held_arr[2]);
    endcase
  end

  // R7: a power write is visible on the next cycle
  p_pwr_write_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && wr_addr_i == A_PWR) |=> (pwr_q == $past(wr_data_i[NUM_CH-1:0])));

  // R8: enables rise only after standby was high two edges before
  p_sb_latency_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(dac_oe_o[1]) |-> $past(standby_i, 2));

  // R3: enables are low in the first cycle after reset release
  p_rst_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (dac_oe_o == 3'b000));
endmodule

// File: tb/aux_dac_bank_tb.sv
`timescale 1ns/1ps
module aux_dac_bank_tb_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          standby;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic [1:0]    rd_addr;
  logic [DW-1:0] rd_data;
  logic [7:0]    gain_code;
  logic [11:0]   freq_code;
  logic [9:0]    ramp_code;
  logic [2:0]    oe, cke;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  aux_dac_bank dut_i (
    .clk(clk), .rst_n(rst_n), .standby_i(standby), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .gain_code_o(gain_code), .freq_code_o(freq_code),
    .ramp_code_o(ramp_code), .dac_oe_o(oe), .dac_clk_en_o(cke)
  );

  // reference model built from the requirements
  logic [1:0]  m_rs, m_sb;
  logic [2:0]  m_pwr;
  logic [11:0] m_code [3];
  logic [11:0] m_out  [3];

  function automatic logic [11:0] chmask(int i);
    return (i == 0) ? 12'h0FF : (i == 1) ? 12'hFFF : 12'h3FF;
  endfunction

  function automatic logic [11:0] rst_code(int i);
    return (i == 1) ? 12'h800 : 12'h000;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !m_rs[1]) begin
      m_sb  <= 2'b00;
      m_pwr <= 3'b010;
      for (int i = 0; i < 3; i++) begin
        m_code[i] <= rst_code(i);
        m_out[i]  <= rst_code(i);
      end
      m_rs <= rst_n ? {m_rs[0], 1'b1} : 2'b00;
    end else begin
      m_rs <= {m_rs[0], 1'b1};
      m_sb <= {m_sb[0], standby};
      if (wr_en && wr_addr == 2'd0) m_pwr <= wr_data[2:0];
      for (int i = 0; i < 3; i++) begin
        logic [11:0] nxt;
        nxt = m_code[i];
        if (wr_en && wr_addr == 2'(i + 1)) nxt = wr_data[11:0] & chmask(i);
        m_code[i] <= nxt;
        if (m_sb[1] && m_pwr[i]) m_out[i] <= nxt;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [DW-1:0] exp);
    rd_addr = a;
    #0.1;
    chk(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic model_cmp();
    logic [2:0] exp_en;
    for (int i = 0; i < 3; i++) exp_en[i] = m_sb[1] & m_pwr[i];
    chk("R2 R8 oe", 32'(oe), 32'(exp_en));
    chk("R2 clk_en", 32'(cke), 32'(exp_en));
    chk("R4 R5 R6 gain", 32'(gain_code), 32'(m_out[0]));
    chk("R4 R5 R6 freq", 32'(freq_code), 32'(m_out[1]));
    chk("R4 R5 R6 ramp", 32'(ramp_code), 32'(m_out[2]));
    chk("R7 R1 read", 32'(rd_data),
        32'((rd_addr == 2'd0) ? {9'd0, m_pwr} : m_code[rd_addr - 2'd1]));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_A0C3));
    rst_n = 1'b0; standby = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R3 reset state
    chk("R3 oe", 32'(oe), 32'h0);
    chk("R3 freq out", 32'(freq_code), 32'h800);
    chk("R3 gain out", 32'(gain_code), 32'h0);
    rd_chk("R3 pwr", 2'd0, 16'h0002);
    rd_chk("R3 gain reg", 2'd1, 16'h0000);
    rd_chk("R3 freq reg", 2'd2, 16'h0800);
    rd_chk("R3 ramp reg", 2'd3, 16'h0000);
    // R8 standby latency
    standby = 1'b1;
    step(1);
    chk("R8 oe after one edge", 32'(oe), 32'h0);
    step(1);
    chk("R8 oe after two edges", 32'(oe), 32'h2);
    step(1);
    chk("R6 freq shown", 32'(freq_code), 32'h800);
    // R5 and R1: write to inactive gain channel
    wr(2'd1, 16'hABCD);
    rd_chk("R1 R5 gain reg", 2'd1, 16'h00CD);
    chk("R5 gain out held", 32'(gain_code), 32'h0);
    // R6 enable by power write
    wr(2'd0, 16'h0007);
    chk("R6 gain not yet", 32'(gain_code), 32'h0);
    step(1);
    chk("R6 gain shown", 32'(gain_code), 32'hCD);
    chk("R2 all enabled", 32'(oe), 32'h7);
    // R4 and R1: live write truncated
    wr(2'd2, 16'h1234);
    chk("R4 R1 freq live", 32'(freq_code), 32'h234);
    wr(2'd3, 16'hFFFF);
    chk("R4 R1 ramp live", 32'(ramp_code), 32'h3FF);
    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      model_cmp();
      wr_en   = ($urandom % 2) == 0;
      wr_addr = 2'($urandom % 4);
      wr_data = 16'($urandom);
      rd_addr = 2'($urandom % 4);
      if (($urandom % 12) == 0) standby = ~standby;
      step(1);
    end
    wr_en = 1'b0;
    // R9 asynchronous reset
    standby = 1'b1;
    wr(2'd0, 16'h0005);
    step(3);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R9 oe cleared", 32'(oe), 32'h0);
    rd_chk("R9 pwr cleared", 2'd0, 16'h0002);
    step(2);
    rst_n = 1'b1;
    step(1);
    chk("R9 still held", 32'(oe), 32'h0);
    step(5);
    model_cmp();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule